// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two component predictors side by side. The first is a table of 2-bit saturating counters addressed by a global history register, which holds the outcomes of the most recent branches. The second is a two-level local predictor: a per-branch history table, addressed by the branch address, supplies a 10-bit pattern that in turn addresses a table of 3-bit saturating counters. A third table of 2-bit counters, addressed by the same global history, learns which of the two components to trust for that history.

A fetch stage presents a PC on the prediction port and receives, one cycle later, the final direction together with the history values used as table indices and both component guesses. When the branch resolves, the caller returns the PC, the real outcome, and those saved indices and guesses on the update port. The block then trains the counters, trains the chooser, and shifts both histories. Table sizes and counter widths are parameters.

Top module: `bp_tournament`

## Requirements
- R1: While `rst` is high, every counter in the two direction tables returns to weakly-not-taken (1 for 2-bit, 3 for 3-bit), every chooser entry returns to 1, which means weakly local, and both histories clear to zero. A prediction after reset is therefore not taken with both indices zero.
- R2: The prediction outputs are registered. They change on the clock edge at which `pred_valid_i` is high and hold their values on every edge where it is low.
- R3: `pred_gidx_o` equals the global history. The global guess is the MSB of the 2-bit counter at that index, and the chooser entry is read at that same index.
- R4: `pred_lidx_o` equals the local history entry selected by PC bits [11:2]. The local guess is 1 when the 3-bit counter at that history value is 4 or more.
- R5: The final direction equals the global guess when the chooser entry is 2 or more (`pred_use_global_o` = 1), and the local guess otherwise.
- R6: On a valid update, the global history shifts left with the outcome entering at bit 0. The local history entry selected by `upd_pc_i` bits [11:2] shifts the same way.
- R7: On a valid update, the 2-bit counter at `upd_gidx_i` and the 3-bit counter at `upd_lidx_i` step one toward the outcome (up for taken) and saturate at 0 and at their maximum.
- R8: The chooser entry at `upd_gidx_i` changes only when `upd_gpred_i` differs from `upd_lpred_i`. It steps up when the global guess matched the outcome and down otherwise, saturating at 0 and 3.
- R9: A prediction made in the same cycle as an update reads the state as it was before that update.
- R10: When `upd_valid_i` is low, no history and no table entry changes, whatever the other update inputs carry.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid_i | input | 1 | Prediction request strobe |
| pred_pc_i | input | 32 | Fetch PC to predict |
| pred_taken_o | output | 1 | Final predicted direction |
| pred_use_global_o | output | 1 | Chooser picked the global component |
| pred_gpred_o | output | 1 | Global component guess |
| pred_lpred_o | output | 1 | Local component guess |
| pred_gidx_o | output | 12 | Global history used as index |
| pred_lidx_o | output | 10 | Local history used as index |
| upd_valid_i | input | 1 | Update strobe |
| upd_pc_i | input | 32 | Resolved branch PC |
| upd_taken_i | input | 1 | Actual outcome |
| upd_gidx_i | input | 12 | Global index saved at prediction time |
| upd_lidx_i | input | 10 | Local index saved at prediction time |
| upd_gpred_i | input | 1 | Global guess saved at prediction time |
| upd_lpred_i | input | 1 | Local guess saved at prediction time |

## Verification
A lookup and a training write can land in the same cycle, and both touch the global history and the tables. The bench provokes this by raising both strobes together while the history holds a known pattern. It expects the reported global index to be the old pattern. The very next lookup must then show that pattern shifted with the new outcome. A separate cycle, in which the update strobe is low but the other update inputs carry live values, shows that the histories stay put.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // One saturating step of an up/down counter of the given width (up to 8 bits).
  function automatic logic [7:0] sat_step(logic [7:0] cur, logic up, int unsigned width);
    logic [7:0] top;
    top = 8'((1 << width) - 1);
    if (up)
      return (cur == top) ? cur : cur + 8'd1;
    else
      return (cur == 8'd0) ? cur : cur - 8'd1;
  endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W   = 12,
  parameter int CNT_W   = 2,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] nxt;

  assign rd_ctr = mem[rd_idx];

  always_comb begin
    nxt = CNT_W'(bp_pkg::sat_step(8'(mem[wr_idx]), wr_up, CNT_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CNT_W'(RST_VAL);
    end else if (wr_en) begin
      mem[wr_idx] <= nxt;
    end
  end
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];
  logic [HIST_W-1:0] cur;

  assign rd_hist = mem[rd_idx];
  assign cur     = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {cur[HIST_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/bp_tournament.sv
module bp_tournament #(
  parameter int PC_W      = 32,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int GCNT_W    = 2,
  parameter int LCNT_W    = 3,
  parameter int CH_W      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pred_valid_i,
  input  logic [PC_W-1:0]    pred_pc_i,
  output logic               pred_taken_o,
  output logic               pred_use_global_o,
  output logic               pred_gpred_o,
  output logic               pred_lpred_o,
  output logic [GHIST_W-1:0] pred_gidx_o,
  output logic [LHIST_W-1:0] pred_lidx_o,
  input  logic               upd_valid_i,
  input  logic [PC_W-1:0]    upd_pc_i,
  input  logic               upd_taken_i,
  input  logic [GHIST_W-1:0] upd_gidx_i,
  input  logic [LHIST_W-1:0] upd_lidx_i,
  input  logic               upd_gpred_i,
  input  logic               upd_lpred_i
);
  localparam int G_WEAK_NT = (1 << (GCNT_W - 1)) - 1;
  localparam int L_WEAK_NT = (1 << (LCNT_W - 1)) - 1;
  localparam int CH_WEAK_L = (1 << (CH_W - 1)) - 1;
  localparam int PC_LO     = 2;
  localparam int PC_HI     = PC_LO + LHT_IDX_W - 1;

  logic [GHIST_W-1:0]   ghr_q;
  logic [LHT_IDX_W-1:0] p_lht_idx, u_lht_idx;
  logic [LHIST_W-1:0]   p_lhist;
  logic [GCNT_W-1:0]    p_gctr;
  logic [LCNT_W-1:0]    p_lctr;
  logic [CH_W-1:0]      p_ch;
  logic                 g_guess, l_guess, use_g;
  logic                 ch_wr;
  logic                 unused_pc_bits;

  assign p_lht_idx = pred_pc_i[PC_HI:PC_LO];
  assign u_lht_idx = upd_pc_i[PC_HI:PC_LO];
  assign unused_pc_bits = ^{pred_pc_i[PC_LO-1:0], pred_pc_i[PC_W-1:PC_HI+1],
                            upd_pc_i[PC_LO-1:0], upd_pc_i[PC_W-1:PC_HI+1]};

  // Global history register
  always_ff @(posedge clk) begin
    if (rst)              ghr_q <= '0;
    else if (upd_valid_i) ghr_q <= {ghr_q[GHIST_W-2:0], upd_taken_i};
  end

  bp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) lht_i (
    .clk(clk), .rst(rst),
    .rd_idx(p_lht_idx), .rd_hist(p_lhist),
    .wr_en(upd_valid_i), .wr_idx(u_lht_idx), .wr_bit(upd_taken_i)
  );

  bp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W), .RST_VAL(G_WEAK_NT)) gtab_i (
    .clk(clk), .rst(rst),
    .rd_idx(ghr_q), .rd_ctr(p_gctr),
    .wr_en(upd_valid_i), .wr_idx(upd_gidx_i), .wr_up(upd_taken_i)
  );

  bp_ctr_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W), .RST_VAL(L_WEAK_NT)) ltab_i (
    .clk(clk), .rst(rst),
    .rd_idx(p_lhist), .rd_ctr(p_lctr),
    .wr_en(upd_valid_i), .wr_idx(upd_lidx_i), .wr_up(upd_taken_i)
  );

  assign ch_wr = upd_valid_i && (upd_gpred_i != upd_lpred_i);

  bp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(CH_W), .RST_VAL(CH_WEAK_L)) chtab_i (
    .clk(clk), .rst(rst),
    .rd_idx(ghr_q), .rd_ctr(p_ch),
    .wr_en(ch_wr), .wr_idx(upd_gidx_i), .wr_up(upd_gpred_i == upd_taken_i)
  );

  assign g_guess = p_gctr[GCNT_W-1];
  assign l_guess = p_lctr[LCNT_W-1];
  assign use_g   = p_ch[CH_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_taken_o      <= 1'b0;
      pred_use_global_o <= 1'b0;
      pred_gpred_o      <= 1'b0;
      pred_lpred_o      <= 1'b0;
      pred_gidx_o       <= '0;
      pred_lidx_o       <= '0;
    end else if (pred_valid_i) begin
      pred_taken_o      <= use_g ? g_guess : l_guess;
      pred_use_global_o <= use_g;
      pred_gpred_o      <= g_guess;
      pred_lpred_o      <= l_guess;
      pred_gidx_o       <= ghr_q;
      pred_lidx_o       <= p_lhist;
    end
  end
endmodule

// File: rtl/bp_tournament_chk.sv
module bp_tournament_chk #(
  parameter int GHIST_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               pred_valid_i,
  input logic               upd_valid_i,
  input logic               upd_taken_i,
  input logic [GHIST_W-1:0] ghr_q,
  input logic [GHIST_W-1:0] pred_gidx_o,
  input logic               pred_taken_o,
  input logic               pred_use_global_o,
  input logic               pred_gpred_o,
  input logic               pred_lpred_o
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!pred_taken_o && !pred_use_global_o && pred_gidx_o == '0 && ghr_q == '0));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_valid_i |=> ($stable(pred_taken_o) && $stable(pred_gidx_o)));

  // R5
  final_pick_chk: assert property (@(posedge clk) disable iff (rst)
    pred_taken_o == (pred_use_global_o ? pred_gpred_o : pred_lpred_o));

  // R6
  hist_shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid_i |=> ghr_q[0] == $past(upd_taken_i));

  // R9
  pre_update_read_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid_i |=> pred_gidx_o == $past(ghr_q));

  // R10
  idle_update_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid_i |=> $stable(ghr_q));
endmodule

bind bp_tournament bp_tournament_chk #(.GHIST_W(GHIST_W)) chk_i (
  .clk(clk), .rst(rst),
  .pred_valid_i(pred_valid_i), .upd_valid_i(upd_valid_i), .upd_taken_i(upd_taken_i),
  .ghr_q(ghr_q), .pred_gidx_o(pred_gidx_o), .pred_taken_o(pred_taken_o),
  .pred_use_global_o(pred_use_global_o), .pred_gpred_o(pred_gpred_o),
  .pred_lpred_o(pred_lpred_o)
);

// File: tb/bp_tournament_tb_top.sv
module bp_tournament_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pred_valid_i = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o, pred_use_global_o, pred_gpred_o, pred_lpred_o;
  logic [11:0] pred_gidx_o;
  logic [9:0]  pred_lidx_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [11:0] upd_gidx_i = '0;
  logic [9:0]  upd_lidx_i = '0;
  logic        upd_gpred_i = 1'b0;
  logic        upd_lpred_i = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bp_tournament dut_i (
    .clk(clk), .rst(rst),
    .pred_valid_i(pred_valid_i), .pred_pc_i(pred_pc_i),
    .pred_taken_o(pred_taken_o), .pred_use_global_o(pred_use_global_o),
    .pred_gpred_o(pred_gpred_o), .pred_lpred_o(pred_lpred_o),
    .pred_gidx_o(pred_gidx_o), .pred_lidx_o(pred_lidx_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i),
    .upd_gidx_i(upd_gidx_i), .upd_lidx_i(upd_lidx_i),
    .upd_gpred_i(upd_gpred_i), .upd_lpred_i(upd_lpred_i)
  );

  typedef struct packed {
    logic [31:0] upc;
    logic        ut;
    logic [11:0] ug;
    logic [9:0]  ul;
    logic        ugp;
    logic        ulp;
    logic [31:0] ppc;
    logic        et;
    logic [11:0] eg;
    logic [9:0]  el;
    logic        egp;
    logic        elp;
    logic        eug;
  } vec_t;

  // Each row: one update, then one lookup whose outputs are compared.
  localparam vec_t VECS [6] = '{
    '{32'h100, 1'b1, 12'h001, 10'h001, 1'b0, 1'b0, 32'h100, 1'b1, 12'h001, 10'h001, 1'b1, 1'b1, 1'b0},
    '{32'h100, 1'b0, 12'h002, 10'h002, 1'b1, 1'b0, 32'h100, 1'b0, 12'h002, 10'h002, 1'b0, 1'b0, 1'b0},
    '{32'h100, 1'b1, 12'h005, 10'h3FF, 1'b1, 1'b0, 32'h100, 1'b1, 12'h005, 10'h005, 1'b1, 1'b0, 1'b1},
    '{32'h100, 1'b0, 12'h00A, 10'h3FE, 1'b0, 1'b1, 32'h100, 1'b0, 12'h00A, 10'h00A, 1'b0, 1'b0, 1'b1},
    '{32'h300, 1'b1, 12'h015, 10'h000, 1'b0, 1'b0, 32'h204, 1'b1, 12'h015, 10'h000, 1'b1, 1'b1, 1'b0},
    '{32'h204, 1'b0, 12'h02A, 10'h3FD, 1'b1, 1'b0, 32'h300, 1'b1, 12'h02A, 10'h001, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_upd(input logic [31:0] pc, input logic t, input logic [11:0] g,
                         input logic [9:0] l, input logic gp, input logic lp);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = t;
    upd_gidx_i = g; upd_lidx_i = l; upd_gpred_i = gp; upd_lpred_i = lp;
  endtask

  task automatic do_upd(input logic [31:0] pc, input logic t, input logic [11:0] g,
                        input logic [9:0] l, input logic gp, input logic lp);
    set_upd(pc, t, g, l, gp, lp);
    step();
    upd_valid_i = 1'b0;
  endtask

  task automatic do_pred(input logic [31:0] pc);
    pred_valid_i = 1'b1; pred_pc_i = pc;
    step();
    pred_valid_i = 1'b0;
  endtask

  // Load the global history with a chosen pattern, oldest bit first.
  task automatic load_ghr(input logic [11:0] val);
    for (int i = 11; i >= 0; i--) do_upd(32'h0, val[i], 12'hFFF, 10'h3FF, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;

    // R1 state after reset
    do_pred(32'h100);
    chk("R1 taken", 32'(pred_taken_o), 0);
    chk("R1 use_global", 32'(pred_use_global_o), 0);
    chk("R1 gidx", 32'(pred_gidx_o), 0);
    chk("R1 lidx", 32'(pred_lidx_o), 0);

    // R3 R4 R5 R6 R7 R8 vector walk
    foreach (VECS[k]) begin
      do_upd(VECS[k].upc, VECS[k].ut, VECS[k].ug, VECS[k].ul, VECS[k].ugp, VECS[k].ulp);
      do_pred(VECS[k].ppc);
      chk($sformatf("R5 vec%0d taken", k), 32'(pred_taken_o), 32'(VECS[k].et));
      chk($sformatf("R3 R6 vec%0d gidx", k), 32'(pred_gidx_o), 32'(VECS[k].eg));
      chk($sformatf("R4 R6 vec%0d lidx", k), 32'(pred_lidx_o), 32'(VECS[k].el));
      chk($sformatf("R3 R7 vec%0d gpred", k), 32'(pred_gpred_o), 32'(VECS[k].egp));
      chk($sformatf("R4 R7 vec%0d lpred", k), 32'(pred_lpred_o), 32'(VECS[k].elp));
      chk($sformatf("R8 vec%0d use_global", k), 32'(pred_use_global_o), 32'(VECS[k].eug));
    end

    // R7 local counter at history 1 is 4: up to 7 and held there, down to 4
    for (int i = 0; i < 4; i++) do_upd(32'h0, 1'b1, 12'hFFF, 10'h001, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) do_upd(32'h0, 1'b0, 12'hFFF, 10'h001, 1'b0, 1'b0);
    do_pred(32'h300);
    chk("R7 local saturate high", 32'(pred_lpred_o), 1);
    do_upd(32'h0, 1'b0, 12'hFFF, 10'h001, 1'b0, 1'b0);
    do_pred(32'h300);
    chk("R7 local below 4", 32'(pred_lpred_o), 0);

    // R8 chooser at 0x5A5 pushed to 3 and held, then one step down to 2
    for (int i = 0; i < 4; i++) do_upd(32'h0, 1'b1, 12'h5A5, 10'h3FF, 1'b1, 1'b0);
    do_upd(32'h0, 1'b0, 12'h5A5, 10'h3FF, 1'b1, 1'b0);
    load_ghr(12'h5A5);
    do_pred(32'h300);
    chk("R8 chooser saturate", 32'(pred_use_global_o), 1);
    chk("R7 global saturate", 32'(pred_gpred_o), 1);
    chk("R5 follows global", 32'(pred_taken_o), 1);

    // R8 agreeing guesses leave chooser alone; R7 global counter drops to 0
    for (int i = 0; i < 2; i++) do_upd(32'h0, 1'b0, 12'h5A5, 10'h3FF, 1'b1, 1'b1);
    load_ghr(12'h5A5);
    do_pred(32'h300);
    chk("R8 agree no change", 32'(pred_use_global_o), 1);
    chk("R5 global not taken", 32'(pred_taken_o), 0);

    // R9 lookup and update in the same cycle
    set_upd(32'h0, 1'b1, 12'hFFF, 10'h3FF, 1'b0, 1'b0);
    do_pred(32'h300);
    upd_valid_i = 1'b0;
    chk("R9 old history seen", 32'(pred_gidx_o), 32'h5A5);
    do_pred(32'h300);
    chk("R6 history shifted", 32'(pred_gidx_o), 32'hB4B);

    // R10 update strobe low with live update inputs
    upd_valid_i = 1'b0; upd_pc_i = 32'h300; upd_taken_i = 1'b1;
    upd_gidx_i = 12'h5A5; upd_lidx_i = 10'h001; upd_gpred_i = 1'b1; upd_lpred_i = 1'b0;
    step();
    do_pred(32'h300);
    chk("R10 global history kept", 32'(pred_gidx_o), 32'hB4B);
    chk("R10 local history kept", 32'(pred_lidx_o), 1);

    // R2 outputs hold while lookup strobe is low
    pred_pc_i = 32'h100;
    do_upd(32'h300, 1'b1, 12'hFFF, 10'h3FF, 1'b0, 1'b0);
    chk("R2 hold gidx", 32'(pred_gidx_o), 32'hB4B);
    chk("R2 hold lidx", 32'(pred_lidx_o), 1);

    // R1 reset in mid run
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    do_pred(32'h300);
    chk("R1 rerun gidx", 32'(pred_gidx_o), 0);
    chk("R1 rerun lidx", 32'(pred_lidx_o), 0);
    chk("R1 rerun lpred", 32'(pred_lpred_o), 0);
    chk("R1 rerun use_global", 32'(pred_use_global_o), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule